// File: doc/BRIEF.md
# Four-Lane Elastic Skip Column Rate Matcher

This block sits between lane deskew and the code-group decoder of a four-lane 8b/10b receive path. It absorbs a frequency offset of up to ±100 ppm between the rate at which aligned columns arrive and the rate at which the core consumes them. A column is four 10-bit code groups, one per lane. Columns enter on a write strobe and leave on a read request. Both strobes are sampled on one shared clock, so a test can model the offset by giving the two strobes different duty patterns.

Columns are held in a 16-entry elastic FIFO with an occupancy counter. The block changes the stream only at skip columns. A skip column is one in which every lane carries K28.0, in either running-disparity form. When the FIFO is running full, an arriving skip column is dropped. When it is running low and the next column to leave is a skip column, a copy is emitted instead of advancing. Each lane of the copy uses the K28.0 form last written on that lane. A one-cycle flag reports each dropped or added column. A sticky fault flag records a write into a full FIFO or a read from an empty one.

Top module: `skip_rate_matcher`

## Requirements
- R1: Columns that are stored leave the FIFO in the order they were written. Lane n occupies bits [10n+9:10n].
- R2: A lane counts as skip when it equals 10'b0011110100 or 10'b1100001011. A column counts as skip only when all four lanes do, and the lanes may mix the two forms.
- R3: A skip column written while occupancy is greater than 9 is not stored, and delEvent is high in the next cycle.
- R4: A written column that is not a skip column, or any column written at occupancy 9 or less, is stored while the FIFO is not full.
- R5: A read request at occupancy 1 to 3 with a skip column at the head emits a skip column and leaves the head in place. rdValid and insEvent are high in the next cycle.
- R6: In an added column, each lane carries the K28.0 form last written on that lane. After reset the form is 10'b0011110100.
- R7: A read request with a non-skip column at the head always consumes that column, whatever the occupancy.
- R8: insEvent and delEvent are never high in the same cycle.
- R9: A write that would be stored while 16 columns are held is discarded, and fault goes high and stays high until reset.
- R10: A read request on an empty FIFO gives rdValid low in the next cycle, and fault goes high and stays high.
- R11: During and just after reset, rdCol is zero and rdValid, insEvent, delEvent and fault are low.
- R12: Outputs change one cycle after the strobe. rdCol holds its value when rdEn is low, and rdValid is then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both sides |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | A column is offered this cycle |
| wrCol | input | 40 | Offered column, four 10-bit lanes |
| rdEn | input | 1 | Core requests one column |
| rdCol | output | 40 | Column delivered for the last request |
| rdValid | output | 1 | rdCol carries a delivered column |
| insEvent | output | 1 | Last delivered column was an added skip column |
| delEvent | output | 1 | Last written column was dropped |
| fault | output | 1 | Sticky overflow or underflow indication |

## Verification
The stream used for testing mixes plain data columns, skip columns with all lanes in one form, skip columns with the forms mixed across lanes, and columns in which only three lanes carry K28.0. Mixed-form columns check that both encodings are recognised. The three-lane columns show that a single non-skip lane is enough to stop a drop. The read pattern drains the FIFO to low occupancy with data at the head and then with a skip column at the head, which separates a head that is consumed from one that is repeated. The lane forms seen in the added columns show which write last updated each lane. Separate runs fill the FIFO past 16 entries and read it empty, to exercise the two fault conditions and to show that reset clears the flag.

// File: rtl/rm_pkg.sv
package rm_pkg;

  localparam int SYM_W = 10;

  // K28.0 in both running-disparity forms
  localparam logic [SYM_W-1:0] SKIP_NEG = 10'b0011110100;
  localparam logic [SYM_W-1:0] SKIP_POS = 10'b1100001011;

  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic look;  // a column is offered: refresh per-lane skip forms
    logic push;  // store offered column
    logic pop;   // advance read pointer, deliver head
    logic ins;   // deliver an added skip column, head stays
    logic emit;  // a read request is being answered
  } rmCtl_t;

  function automatic logic isSkip(input logic [SYM_W-1:0] sym);
    return (sym == SKIP_NEG) || (sym == SKIP_POS);
  endfunction

endpackage

// File: rtl/rm_control.sv
module rm_control #(
  parameter int DEPTH     = 16,
  parameter int DEL_ABOVE = 9,
  parameter int INS_BELOW = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           wrEn,
  input  logic           rdEn,
  input  logic           inAllSkip,
  input  logic           headAllSkip,
  output rm_pkg::rmCtl_t ctl,
  output logic           insEvent,
  output logic           delEvent,
  output logic           fault
);

  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [OCC_W-1:0] FULL_LVL = OCC_W'(DEPTH);
  localparam logic [OCC_W-1:0] DEL_TH   = OCC_W'(DEL_ABOVE);
  localparam logic [OCC_W-1:0] INS_TH   = OCC_W'(INS_BELOW);

  logic [OCC_W-1:0] occ;
  logic             isEmpty, isFull;
  logic             drop, addSkip, take, store;
  logic             overflow, underflow;

  assign isEmpty = (occ == '0);
  assign isFull  = (occ == FULL_LVL);

  // write side: drop a whole skip column only when running full
  assign drop  = wrEn && inAllSkip && (occ > DEL_TH);
  assign store = wrEn && !drop && !isFull;
  assign overflow = wrEn && !drop && isFull;

  // read side: repeat only a skip column at the head when running low
  assign addSkip   = rdEn && !isEmpty && (occ < INS_TH) && headAllSkip;
  assign take      = rdEn && !isEmpty && !addSkip;
  assign underflow = rdEn && isEmpty;

  always_comb begin
    ctl      = '0;
    ctl.look = wrEn;
    ctl.push = store;
    ctl.pop  = take;
    ctl.ins  = addSkip;
    ctl.emit = rdEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occ      <= '0;
      insEvent <= 1'b0;
      delEvent <= 1'b0;
      fault    <= 1'b0;
    end else begin
      case ({store, take})
        2'b10:   occ <= occ + OCC_W'(1);
        2'b01:   occ <= occ - OCC_W'(1);
        default: occ <= occ;
      endcase
      insEvent <= addSkip;
      delEvent <= drop;
      if (overflow || underflow) fault <= 1'b1;
    end
  end

  a_r8_single_event: assert property (@(posedge clk) disable iff (!rstN)
    !(insEvent && delEvent));

  a_r9_fault_sticky: assert property (@(posedge clk) disable iff (!rstN)
    fault |=> fault);

  a_r9_occ_in_range: assert property (@(posedge clk) disable iff (!rstN)
    occ <= FULL_LVL);

  a_r3_drop_when_high: assert property (@(posedge clk) disable iff (!rstN)
    delEvent |-> $past(occ) > DEL_TH);

  a_r5_add_when_low: assert property (@(posedge clk) disable iff (!rstN)
    insEvent |-> ($past(occ) < INS_TH) && ($past(occ) != '0));

endmodule

// File: rtl/rm_datapath.sv
module rm_datapath #(
  parameter int LANES = 4,
  parameter int DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [LANES*rm_pkg::SYM_W-1:0] wrCol,
  input  rm_pkg::rmCtl_t                 ctl,
  output logic                           inAllSkip,
  output logic                           headAllSkip,
  output logic [LANES*rm_pkg::SYM_W-1:0] rdCol,
  output logic                           rdValid
);

  localparam int SW    = rm_pkg::SYM_W;
  localparam int COL_W = LANES * SW;
  localparam int PTR_W = $clog2(DEPTH);

  logic [COL_W-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [COL_W-1:0] headCol, fillCol;
  logic [LANES-1:0] inSkip, headSkip;
  logic [LANES-1:0][SW-1:0] lastForm;

  assign headCol = store[rdPtr];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign inSkip[l]   = rm_pkg::isSkip(wrCol[l*SW +: SW]);
    assign headSkip[l] = rm_pkg::isSkip(headCol[l*SW +: SW]);
    assign fillCol[l*SW +: SW] = lastForm[l];
  end

  assign inAllSkip   = &inSkip;
  assign headAllSkip = &headSkip;

  // per-lane memory of the K28.0 form last offered on that lane
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int l = 0; l < LANES; l++) lastForm[l] <= rm_pkg::SKIP_NEG;
    end else if (ctl.look) begin
      for (int l = 0; l < LANES; l++)
        if (inSkip[l]) lastForm[l] <= wrCol[l*SW +: SW];
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.push) store[wrPtr] <= wrCol;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      rdCol   <= '0;
      rdValid <= 1'b0;
    end else begin
      if (ctl.push) wrPtr <= wrPtr + PTR_W'(1);
      if (ctl.pop)  rdPtr <= rdPtr + PTR_W'(1);
      rdValid <= ctl.pop || ctl.ins;
      if (ctl.emit) rdCol <= ctl.pop ? headCol : fillCol;
    end
  end

  a_r5_head_kept: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ins |=> $stable(rdPtr));

  a_r4_push_advances: assert property (@(posedge clk) disable iff (!rstN)
    ctl.push |=> wrPtr == $past(wrPtr) + PTR_W'(1));

  a_r3_drop_no_store: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.look && !ctl.push) |=> $stable(wrPtr));

  a_r10_empty_read_invalid: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.emit && !ctl.pop && !ctl.ins) |=> !rdValid);

  a_r12_valid_needs_request: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(ctl.emit));

  a_r12_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.emit |=> $stable(rdCol));

endmodule

// File: rtl/skip_rate_matcher.sv
module skip_rate_matcher #(
  parameter int LANES     = 4,
  parameter int DEPTH     = 16,
  parameter int DEL_ABOVE = 9,
  parameter int INS_BELOW = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [LANES*rm_pkg::SYM_W-1:0] wrCol,
  input  logic                           rdEn,
  output logic [LANES*rm_pkg::SYM_W-1:0] rdCol,
  output logic                           rdValid,
  output logic                           insEvent,
  output logic                           delEvent,
  output logic                           fault
);

  rm_pkg::rmCtl_t ctl;
  logic           inAllSkip, headAllSkip;

  rm_control #(
    .DEPTH     (DEPTH),
    .DEL_ABOVE (DEL_ABOVE),
    .INS_BELOW (INS_BELOW)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .rdEn        (rdEn),
    .inAllSkip   (inAllSkip),
    .headAllSkip (headAllSkip),
    .ctl         (ctl),
    .insEvent    (insEvent),
    .delEvent    (delEvent),
    .fault       (fault)
  );

  rm_datapath #(
    .LANES (LANES),
    .DEPTH (DEPTH)
  ) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .wrCol       (wrCol),
    .ctl         (ctl),
    .inAllSkip   (inAllSkip),
    .headAllSkip (headAllSkip),
    .rdCol       (rdCol),
    .rdValid     (rdValid)
  );

  a_r8_no_add_on_drop: assert property (@(posedge clk) disable iff (!rstN)
    insEvent |-> rdValid);

endmodule

// File: tb/skip_rate_matcher_tb.sv
module skip_rate_matcher_tb;

  localparam logic [9:0] SN = 10'b0011110100;
  localparam logic [9:0] SP = 10'b1100001011;
  localparam int N = 46;
  // {wr, rd, kind}; kind 0 data, 1 skip all neg, 2 skip mixed, 3 three-lane skip
  localparam logic [3:0] SEQ [N] = '{
    4'd8, 4'd8, 4'd8, 4'd8, 4'd8, 4'd8, 4'd8, 4'd8, 4'd8, 4'd8,
    4'd9, 4'd11, 4'd10, 4'd13,
    4'd4, 4'd4, 4'd4, 4'd4, 4'd4, 4'd4, 4'd4, 4'd4,
    4'd10, 4'd10, 4'd8, 4'd4, 4'd0, 4'd4, 4'd4, 4'd4,
    4'd12, 4'd4, 4'd4, 4'd9, 4'd4, 4'd4, 4'd4, 4'd4,
    4'd8, 4'd8, 4'd8, 4'd4, 4'd4, 4'd4, 4'd4, 4'd4
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [39:0] wrCol = '0;
  logic [39:0] rdCol;
  logic        rdValid, insEvent, delEvent, fault;

  always #2.5 clk = ~clk;

  skip_rate_matcher u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrCol(wrCol), .rdEn(rdEn),
    .rdCol(rdCol), .rdValid(rdValid), .insEvent(insEvent),
    .delEvent(delEvent), .fault(fault)
  );

  int testCnt = 0, failCnt = 0;
  int nIns = 0, nDel = 0, nDelMixed = 0, nUnf = 0, nLowDataPop = 0, nCoinc = 0;

  // reference model state
  logic [39:0] mq [16];
  int mh, mt, mocc;
  logic [9:0] mLast [4];
  logic [39:0] eCol;
  logic eValid, eIns, eDel, eFault;

  function automatic logic allSkip(input logic [39:0] c);
    for (int l = 0; l < 4; l++)
      if (c[l*10 +: 10] != SN && c[l*10 +: 10] != SP) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [39:0] makeCol(input int kind, input int idx);
    logic [39:0] c;
    for (int l = 0; l < 4; l++) begin
      case (kind)
        1: c[l*10 +: 10] = SN;
        2: c[l*10 +: 10] = l[0] ? SP : SN;
        3: c[l*10 +: 10] = (l == 3) ? 10'(10'h100 + idx * 4 + l) : SN;
        default: c[l*10 +: 10] = 10'(10'h100 + (idx % 64) * 4 + l);
      endcase
    end
    return c;
  endfunction

  task automatic modelReset();
    mh = 0; mt = 0; mocc = 0;
    for (int l = 0; l < 4; l++) mLast[l] = SN;
    eCol = '0; eValid = 0; eIns = 0; eDel = 0; eFault = 0;
  endtask

  task automatic check(input string tag, input int stepNo);
    testCnt++;
    if (insEvent && delEvent) nCoinc++;
    if (rdCol !== eCol || rdValid !== eValid || insEvent !== eIns ||
        delEvent !== eDel || fault !== eFault) begin
      failCnt++;
      $display("FAIL %s step %0d: got col=%h v=%b ins=%b del=%b flt=%b exp col=%h v=%b ins=%b del=%b flt=%b",
               tag, stepNo, rdCol, rdValid, insEvent, delEvent, fault,
               eCol, eValid, eIns, eDel, eFault);
    end
  endtask

  // drive one cycle at the falling edge, update model, compare one cycle later
  task automatic doStep(input logic wr, input logic rd, input logic [39:0] col,
                        input int stepNo);
    logic drop, ins, pop, push, ovf, unf, headSkip;
    logic [39:0] fill;
    string tag;
    for (int l = 0; l < 4; l++) fill[l*10 +: 10] = mLast[l];
    headSkip = (mocc > 0) && allSkip(mq[mh]);
    drop = wr && allSkip(col) && (mocc > 9);
    ins  = rd && (mocc > 0) && (mocc < 4) && headSkip;
    pop  = rd && (mocc > 0) && !ins;
    push = wr && !drop && (mocc < 16);
    ovf  = wr && !drop && (mocc == 16);
    unf  = rd && (mocc == 0);
    if (rd) begin
      eCol = pop ? mq[mh] : fill;
      eValid = pop || ins;
    end else eValid = 1'b0;
    eIns = ins; eDel = drop;
    if (ovf || unf) eFault = 1'b1;
    if (drop) begin nDel++; if (col[9:0] != col[19:10]) nDelMixed++; end
    if (ins) nIns++;
    if (unf) nUnf++;
    if (pop && mocc < 4 && !headSkip) nLowDataPop++;
    if (drop)                   tag = "R3";
    else if (ins)               tag = "R6";
    else if (unf)               tag = "R10";
    else if (ovf)               tag = "R9";
    else if (pop && mocc < 4)   tag = "R7";
    else if (wr && !allSkip(col) && col[9:0] == SN) tag = "R4";
    else if (!rd)               tag = "R12";
    else                        tag = "R1";
    if (wr) for (int l = 0; l < 4; l++)
      if (col[l*10 +: 10] == SN || col[l*10 +: 10] == SP) mLast[l] = col[l*10 +: 10];
    if (push) begin mq[mt] = col; mt = (mt + 1) % 16; end
    if (pop) mh = (mh + 1) % 16;
    mocc = mocc + (push ? 1 : 0) - (pop ? 1 : 0);
    wrEn = wr; rdEn = rd; wrCol = col;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check(tag, stepNo);
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0;
    modelReset();
    repeat (2) @(negedge clk);
    check("R11", -1);
    rstN = 1'b1;
  endtask

  task automatic tally(input string tag, input logic ok, input int got, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    applyReset();
    // vector walk
    for (int i = 0; i < N; i++)
      doStep(SEQ[i][3], SEQ[i][2], makeCol(int'(SEQ[i][1:0]), i), i);
    tally("R3 drops seen", nDel > 0, nDel, 1);
    tally("R2 mixed-form drop seen", nDelMixed > 0, nDelMixed, 1);
    tally("R5 additions seen", nIns > 0, nIns, 1);
    tally("R7 low-level data consumed", nLowDataPop > 0, nLowDataPop, 1);
    tally("R10 empty read seen", nUnf > 0, nUnf, 1);

    // overflow: fill 16, write a 17th, then read the first back
    applyReset();
    for (int i = 0; i < 17; i++) doStep(1'b1, 1'b0, makeCol(0, 20 + i), 100 + i);
    tally("R9 fault after overflow", fault === 1'b1, int'(fault), 1);
    doStep(1'b0, 1'b1, '0, 200);
    tally("R9 first column kept", rdCol === makeCol(0, 20), int'(rdCol[9:0]), int'(makeCol(0, 20) >> 0) & 1023);
    doStep(1'b0, 1'b0, '0, 201);
    tally("R9 fault sticky", fault === 1'b1, int'(fault), 1);
    // skip write at full level is dropped, not a fault path
    applyReset();
    tally("R11 fault cleared by reset", fault === 1'b0, int'(fault), 0);
    tally("R8 events never coincided", nCoinc == 0, nCoinc, 0);

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule